// File: doc/BRIEF.md
# Multi-Channel Scan Timing Controller

This block paces a data acquisition that is organised as a number of scans, each made of a fixed number of channel conversions. Four settings describe the run: the spacing between conversions inside a scan, the spacing between the starts of two scans, the channel count per scan and the scan count. A start trigger launches the run. An optional delay can be counted before the first conversion, or the first conversion can follow the trigger directly. Every spacing is counted in ticks. A tick comes either from the internal timebase (one per clock) or from the rising edge of one of three external pulse inputs.

The block drives a one-cycle conversion strobe with the channel index that belongs to it. It also drives a pulse that marks the first conversion of every scan, a level that covers each scan, and a level that covers the whole acquisition. A setting that cannot fit its channels into the scan spacing is refused, and an error flag is raised instead. The converter itself, data storage and transfer are handled elsewhere.

Top module: `scan_timing_ctrl`

## Requirements
- R1: The four counter settings, the delay and the tick source are captured when a trigger is accepted. Changing the configuration inputs during an acquisition has no effect on that acquisition.
- R2: Ticks are numbered from 0, starting at the first clock edge after the accepting edge, and only ticks in that window count. Channel c of scan s (both counted from 0) is converted at tick D + s*SCAN + c*SAMPLE. The strobe is high for one cycle, in the cycle after the edge at which that tick is sampled.
- R3: An acquisition gives exactly CH*SCANS strobes. For example, 4 channels and 3 scans give 12 strobes.
- R4: During a strobe, chan_idx equals the channel number within the scan. It is 0 on the first strobe of every scan, and it holds its value between strobes.
- R5: scan_start is high together with the strobe of channel 0, and only then. scan_busy rises with that strobe and stays high through the strobe of the last channel. It falls in the next cycle unless a new scan starts in that same cycle.
- R6: acq_busy rises in the cycle after the accepting edge. It stays high through the last strobe and falls one cycle later, after which the block is idle.
- R7: With cfg_delay_en high, D equals cfg_delay. With cfg_delay_en low, D is 0, so the first strobe appears two cycles after the trigger is driven when the timebase is selected.
- R8: cfg_src selects the tick source: 0 = internal timebase (every clock), 1 = ext_pulse, 2 = tmr_a_pulse, 3 = tmr_b_pulse. An external input gives a tick only in a cycle where it is high and was low in the previous cycle. An input held high gives one tick.
- R9: A trigger is accepted only if SAMPLE >= 1, CH >= 1, SCANS >= 1 and SCAN >= CH*SAMPLE. Otherwise no acquisition starts and cfg_err goes high in the cycle after the trigger edge. cfg_err stays high until the next accepted trigger clears it.
- R10: A trigger that arrives while acq_busy is high is ignored. The strobe count, timing and cfg_err are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig | input | 1 | Start trigger, sampled on each edge |
| cfg_sample_ivl | input | CNT_W | Ticks between conversions in a scan (SAMPLE) |
| cfg_scan_ivl | input | CNT_W | Ticks between scan starts (SCAN) |
| cfg_num_ch | input | CH_W | Channels per scan (CH) |
| cfg_num_scans | input | SCAN_W | Scans per acquisition (SCANS) |
| cfg_delay | input | DLY_W | Ticks of delay before the first conversion |
| cfg_delay_en | input | 1 | 1 = delayed start, 0 = start on the first tick |
| cfg_src | input | 2 | Tick source select |
| ext_pulse | input | 1 | External tick input |
| tmr_a_pulse | input | 1 | Tick input from general-purpose timer A |
| tmr_b_pulse | input | 1 | Tick input from general-purpose timer B |
| conv_strobe | output | 1 | One-cycle conversion strobe |
| chan_idx | output | CH_W | Channel number of the current or last strobe |
| scan_start | output | 1 | First conversion of a scan |
| scan_busy | output | 1 | Scan in progress |
| acq_busy | output | 1 | Acquisition in progress |
| cfg_err | output | 1 | Last trigger refused because of an invalid setting |

## Verification
Every output is registered. The reference model therefore updates on the same rising edge as the design and predicts each output for the cycle that follows that edge. The comparison is made at the falling edge of every clock.

With the timebase selected, acq_busy and cfg_err appear one cycle after the trigger is driven. The first strobe appears D+2 cycles after the trigger is driven, and the bench measures this with its own falling-edge counter for D = 0 and D = 5. With an external source, the strobe follows the rising edge of the pulse by one cycle.

acq_busy falls one cycle after the last strobe, and the bench counts strobes up to that point to check the total. For triggers that should be ignored, the bench checks through the strobe count and the busy and error levels that nothing changed.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RUN    = 2'd1,
      ST_FINISH = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      SRC_TIMEBASE = 2'd0,
      SRC_EXT      = 2'd1,
      SRC_TMR_A    = 2'd2,
      SRC_TMR_B    = 2'd3
   } tick_src_e;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/scan_tick_sel.sv
module scan_tick_sel
   import scan_timing_pkg::*;
#(
   parameter int N_EXT         = 3,
   parameter bit EXT_RISE_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       src_i,
   input  logic [N_EXT-1:0] ext_raw_i,
   output logic             tick_o
);

   logic [N_EXT-1:0] ext_qual;

   generate
      if (EXT_RISE_EDGE) begin : g_edge
         logic [N_EXT-1:0] ext_prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ext_prev_q <= '0;
            else        ext_prev_q <= ext_raw_i;
         end
         assign ext_qual = ext_raw_i & ~ext_prev_q;

         // R8
         ext_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i == SRC_EXT && tick_o) |=> !(src_i == SRC_EXT && tick_o));
      end else begin : g_level
         assign ext_qual = ext_raw_i;
      end
   endgenerate

   always_comb begin
      tick_o = 1'b0;
      case (src_i)
         SRC_TIMEBASE: tick_o = 1'b1;
         SRC_EXT:      tick_o = ext_qual[0];
         SRC_TMR_A:    tick_o = ext_qual[1];
         SRC_TMR_B:    tick_o = ext_qual[2];
         default:      tick_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/scan_cfg_check.sv
module scan_cfg_check #(
   parameter int CNT_W  = 16,
   parameter int CH_W   = 4,
   parameter int SCAN_W = 12
) (
   input  logic [CNT_W-1:0]  sample_ivl_i,
   input  logic [CNT_W-1:0]  scan_ivl_i,
   input  logic [CH_W-1:0]   num_ch_i,
   input  logic [SCAN_W-1:0] num_scans_i,
   output logic              cfg_ok_o
);

   localparam int PROD_W = CNT_W + CH_W;

   logic [PROD_W-1:0] burst_len;
   logic              fits;
   logic              nonzero;

   assign burst_len = PROD_W'(num_ch_i) * PROD_W'(sample_ivl_i);
   assign fits      = PROD_W'(scan_ivl_i) >= burst_len;
   assign nonzero   = (sample_ivl_i != '0) && (num_ch_i != '0) && (num_scans_i != '0);
   assign cfg_ok_o  = fits && nonzero;

endmodule

// File: rtl/scan_seq_core.sv
module scan_seq_core
   import scan_timing_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int CH_W   = 4,
   parameter int SCAN_W = 12,
   parameter int DLY_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic              cfg_ok_i,
   input  logic [CNT_W-1:0]  sample_ivl_i,
   input  logic [CNT_W-1:0]  scan_ivl_i,
   input  logic [CH_W-1:0]   num_ch_i,
   input  logic [SCAN_W-1:0] num_scans_i,
   input  logic [DLY_W-1:0]  delay_i,
   input  logic              delay_en_i,
   input  logic [1:0]        src_i,
   input  logic              tick_i,
   output logic [1:0]        src_q_o,
   output logic              strobe_o,
   output logic [CH_W-1:0]   chan_o,
   output logic              scan_start_o,
   output logic              scan_busy_o,
   output logic              acq_busy_o,
   output logic              cfg_err_o
);

   localparam int WAIT_W = max_int(CNT_W, DLY_W);
   localparam int PROD_W = CNT_W + CH_W;

   seq_state_e        st_q;
   logic [WAIT_W-1:0] wait_q;
   logic [CNT_W-1:0]  s_ivl_q;
   logic [CNT_W-1:0]  sc_ivl_q;
   logic [CH_W-1:0]   n_ch_q;
   logic [SCAN_W-1:0] scans_left_q;
   logic [CH_W-1:0]   ch_cnt_q;
   logic [1:0]        src_q;
   logic              strobe_q;
   logic [CH_W-1:0]   chan_q;
   logic              start_q;
   logic              sbusy_q;
   logic              err_q;

   logic [PROD_W-1:0] burst_span;
   logic [PROD_W-1:0] gap_full;
   logic [WAIT_W-1:0] gap_wait;
   logic [WAIT_W-1:0] sample_wait;
   logic              last_ch;
   logic              fire;

   // ticks from the last conversion of a scan to the first of the next
   assign burst_span  = PROD_W'(n_ch_q - 1'b1) * PROD_W'(s_ivl_q);
   assign gap_full    = PROD_W'(sc_ivl_q) - burst_span - PROD_W'(1);
   assign gap_wait    = WAIT_W'(gap_full);
   assign sample_wait = WAIT_W'(s_ivl_q) - WAIT_W'(1);
   assign last_ch     = (ch_cnt_q == n_ch_q - 1'b1);
   assign fire        = (st_q == ST_RUN) && tick_i && (wait_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q         <= ST_IDLE;
         wait_q       <= '0;
         s_ivl_q      <= CNT_W'(1);
         sc_ivl_q     <= CNT_W'(1);
         n_ch_q       <= CH_W'(1);
         scans_left_q <= '0;
         ch_cnt_q     <= '0;
         src_q        <= SRC_TIMEBASE;
         strobe_q     <= 1'b0;
         chan_q       <= '0;
         start_q      <= 1'b0;
         sbusy_q      <= 1'b0;
         err_q        <= 1'b0;
      end else begin
         strobe_q <= 1'b0;
         start_q  <= 1'b0;
         if (strobe_q && (chan_q == n_ch_q - 1'b1)) sbusy_q <= 1'b0;

         case (st_q)
            ST_IDLE: begin
               if (trig_i) begin
                  if (cfg_ok_i) begin
                     s_ivl_q      <= sample_ivl_i;
                     sc_ivl_q     <= scan_ivl_i;
                     n_ch_q       <= num_ch_i;
                     scans_left_q <= num_scans_i - 1'b1;
                     src_q        <= src_i;
                     ch_cnt_q     <= '0;
                     wait_q       <= delay_en_i ? WAIT_W'(delay_i) : '0;
                     err_q        <= 1'b0;
                     st_q         <= ST_RUN;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_RUN: begin
               if (tick_i) begin
                  if (!fire) begin
                     wait_q <= wait_q - 1'b1;
                  end else begin
                     strobe_q <= 1'b1;
                     chan_q   <= ch_cnt_q;
                     if (ch_cnt_q == '0) begin
                        start_q <= 1'b1;
                        sbusy_q <= 1'b1;
                     end
                     if (!last_ch) begin
                        ch_cnt_q <= ch_cnt_q + 1'b1;
                        wait_q   <= sample_wait;
                     end else if (scans_left_q != '0) begin
                        scans_left_q <= scans_left_q - 1'b1;
                        ch_cnt_q     <= '0;
                        wait_q       <= gap_wait;
                     end else begin
                        st_q <= ST_FINISH;
                     end
                  end
               end
            end
            ST_FINISH: st_q <= ST_IDLE;
            default:   st_q <= ST_IDLE;
         endcase
      end
   end

   assign src_q_o      = src_q;
   assign strobe_o     = strobe_q;
   assign chan_o       = chan_q;
   assign scan_start_o = start_q;
   assign scan_busy_o  = sbusy_q;
   assign acq_busy_o   = (st_q != ST_IDLE);
   assign cfg_err_o    = err_q;

   // R6
   busy_covers_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> acq_busy_o);
   // R4
   chan_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_q |-> (chan_q < n_ch_q));
   // R5
   start_on_ch0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |-> (strobe_q && chan_q == '0));
   // R5
   scan_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_q && chan_q == n_ch_q - 1'b1) |=> (!sbusy_q || start_q));
   // R6
   idle_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acq_busy_o) |-> $past(strobe_q));
   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acq_busy_o |=> $stable(err_q));
   // R9
   err_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> !acq_busy_o);

endmodule

// File: rtl/scan_timing_ctrl.sv
module scan_timing_ctrl
   import scan_timing_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter int CH_W          = 4,
   parameter int SCAN_W        = 12,
   parameter int DLY_W         = 16,
   parameter bit EXT_RISE_EDGE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig,
   input  logic [CNT_W-1:0]  cfg_sample_ivl,
   input  logic [CNT_W-1:0]  cfg_scan_ivl,
   input  logic [CH_W-1:0]   cfg_num_ch,
   input  logic [SCAN_W-1:0] cfg_num_scans,
   input  logic [DLY_W-1:0]  cfg_delay,
   input  logic              cfg_delay_en,
   input  logic [1:0]        cfg_src,
   input  logic              ext_pulse,
   input  logic              tmr_a_pulse,
   input  logic              tmr_b_pulse,
   output logic              conv_strobe,
   output logic [CH_W-1:0]   chan_idx,
   output logic              scan_start,
   output logic              scan_busy,
   output logic              acq_busy,
   output logic              cfg_err
);

   localparam int N_EXT = 3;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("scan_timing_ctrl: CNT_W out of range");
      end
      if (CH_W < 1 || CH_W > 8) begin : g_bad_ch
         $error("scan_timing_ctrl: CH_W out of range");
      end
      if (SCAN_W < 1 || SCAN_W > 32) begin : g_bad_scan
         $error("scan_timing_ctrl: SCAN_W out of range");
      end
      if (DLY_W < 1 || DLY_W > 32) begin : g_bad_dly
         $error("scan_timing_ctrl: DLY_W out of range");
      end
   endgenerate

   logic             cfg_ok;
   logic             tick;
   logic [1:0]       src_q;
   logic [N_EXT-1:0] ext_raw;

   assign ext_raw = {tmr_b_pulse, tmr_a_pulse, ext_pulse};

   scan_cfg_check #(
      .CNT_W (CNT_W),
      .CH_W  (CH_W),
      .SCAN_W(SCAN_W)
   ) u_cfg_check (
      .sample_ivl_i(cfg_sample_ivl),
      .scan_ivl_i  (cfg_scan_ivl),
      .num_ch_i    (cfg_num_ch),
      .num_scans_i (cfg_num_scans),
      .cfg_ok_o    (cfg_ok)
   );

   scan_tick_sel #(
      .N_EXT        (N_EXT),
      .EXT_RISE_EDGE(EXT_RISE_EDGE)
   ) u_tick_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_i    (src_q),
      .ext_raw_i(ext_raw),
      .tick_o   (tick)
   );

   scan_seq_core #(
      .CNT_W (CNT_W),
      .CH_W  (CH_W),
      .SCAN_W(SCAN_W),
      .DLY_W (DLY_W)
   ) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .trig_i      (trig),
      .cfg_ok_i    (cfg_ok),
      .sample_ivl_i(cfg_sample_ivl),
      .scan_ivl_i  (cfg_scan_ivl),
      .num_ch_i    (cfg_num_ch),
      .num_scans_i (cfg_num_scans),
      .delay_i     (cfg_delay),
      .delay_en_i  (cfg_delay_en),
      .src_i       (cfg_src),
      .tick_i      (tick),
      .src_q_o     (src_q),
      .strobe_o    (conv_strobe),
      .chan_o      (chan_idx),
      .scan_start_o(scan_start),
      .scan_busy_o (scan_busy),
      .acq_busy_o  (acq_busy),
      .cfg_err_o   (cfg_err)
   );

endmodule

// File: tb/scan_timing_ctrl_bench.sv
module scan_timing_ctrl_bench;

   localparam int CNT_W  = 16;
   localparam int CH_W   = 4;
   localparam int SCAN_W = 12;
   localparam int DLY_W  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              trig = 1'b0;
   logic [CNT_W-1:0]  cfg_sample_ivl = '0;
   logic [CNT_W-1:0]  cfg_scan_ivl = '0;
   logic [CH_W-1:0]   cfg_num_ch = '0;
   logic [SCAN_W-1:0] cfg_num_scans = '0;
   logic [DLY_W-1:0]  cfg_delay = '0;
   logic              cfg_delay_en = 1'b0;
   logic [1:0]        cfg_src = 2'd0;
   logic              ext_pulse = 1'b0;
   logic              tmr_a_pulse = 1'b0;
   logic              tmr_b_pulse = 1'b0;
   logic              conv_strobe;
   logic [CH_W-1:0]   chan_idx;
   logic              scan_start;
   logic              scan_busy;
   logic              acq_busy;
   logic              cfg_err;

   always #2 clk = ~clk;

   scan_timing_ctrl u_scan_timing_ctrl (
      .clk(clk), .rst_n(rst_n), .trig(trig),
      .cfg_sample_ivl(cfg_sample_ivl), .cfg_scan_ivl(cfg_scan_ivl),
      .cfg_num_ch(cfg_num_ch), .cfg_num_scans(cfg_num_scans),
      .cfg_delay(cfg_delay), .cfg_delay_en(cfg_delay_en), .cfg_src(cfg_src),
      .ext_pulse(ext_pulse), .tmr_a_pulse(tmr_a_pulse), .tmr_b_pulse(tmr_b_pulse),
      .conv_strobe(conv_strobe), .chan_idx(chan_idx), .scan_start(scan_start),
      .scan_busy(scan_busy), .acq_busy(acq_busy), .cfg_err(cfg_err)
   );

   int n_checks = 0;
   int n_fails  = 0;
   int n_strobes = 0;
   bit done = 1'b0;
   bit ext_run = 1'b0;
   bit tmr_a_run = 1'b0;
   int ext_phase = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_state, m_tick, m_j;
   int m_s, m_sc, m_n, m_scans, m_d, m_src;
   int e_strobe, e_chan, e_start, e_sbusy, e_busy, e_err;
   int p_ext, p_ta, p_tb;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_tick = 0; m_j = 0;
         m_s = 1; m_sc = 1; m_n = 1; m_scans = 1; m_d = 0; m_src = 0;
         e_strobe = 0; e_chan = 0; e_start = 0; e_sbusy = 0; e_busy = 0; e_err = 0;
         p_ext = 0; p_ta = 0; p_tb = 0;
      end else begin
         int tk, prev_strobe, prev_chan, fired, ev, n_in, s_in, sc_in, scn_in;
         case (m_src)
            0: tk = 1;
            1: tk = (ext_pulse && !p_ext) ? 1 : 0;
            2: tk = (tmr_a_pulse && !p_ta) ? 1 : 0;
            default: tk = (tmr_b_pulse && !p_tb) ? 1 : 0;
         endcase
         p_ext = ext_pulse; p_ta = tmr_a_pulse; p_tb = tmr_b_pulse;
         prev_strobe = e_strobe; prev_chan = e_chan;
         e_strobe = 0; e_start = 0; fired = 0;
         if (m_state == 0) begin
            if (trig) begin
               n_in = int'(cfg_num_ch); s_in = int'(cfg_sample_ivl);
               sc_in = int'(cfg_scan_ivl); scn_in = int'(cfg_num_scans);
               if (s_in >= 1 && n_in >= 1 && scn_in >= 1 && sc_in >= n_in * s_in) begin
                  m_s = s_in; m_sc = sc_in; m_n = n_in; m_scans = scn_in;
                  m_d = cfg_delay_en ? int'(cfg_delay) : 0;
                  m_src = int'(cfg_src);
                  m_tick = 0; m_j = 0; m_state = 1; e_err = 0;
               end else begin
                  e_err = 1;
               end
            end
         end else if (m_state == 1) begin
            if (tk != 0) begin
               ev = m_d + (m_j / m_n) * m_sc + (m_j % m_n) * m_s;
               if (m_tick == ev) begin
                  fired = 1; e_strobe = 1; e_chan = m_j % m_n;
                  e_start = (e_chan == 0) ? 1 : 0;
                  m_j++;
                  if (m_j == m_n * m_scans) m_state = 2;
               end
               m_tick++;
            end
         end else begin
            m_state = 0;
         end
         if (fired != 0 && e_chan == 0) e_sbusy = 1;
         else if (prev_strobe != 0 && prev_chan == m_n - 1) e_sbusy = 0;
         e_busy = (m_state != 0) ? 1 : 0;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2", "conv_strobe", int'(conv_strobe), e_strobe);
         check("R4", "chan_idx", int'(chan_idx), e_chan);
         check("R5", "scan_start", int'(scan_start), e_start);
         check("R5", "scan_busy", int'(scan_busy), e_sbusy);
         check("R6", "acq_busy", int'(acq_busy), e_busy);
         check("R9", "cfg_err", int'(cfg_err), e_err);
         if (conv_strobe) n_strobes++;
      end
   end

   // external pulse generator: one high cycle out of three
   always @(negedge clk) begin
      if (ext_run) begin
         ext_pulse <= (ext_phase == 0);
         ext_phase <= (ext_phase == 2) ? 0 : ext_phase + 1;
      end else begin
         ext_pulse <= 1'b0;
      end
      if (tmr_a_run) tmr_a_pulse <= ~tmr_a_pulse;
   end

   task automatic setup(input int s, input int sc, input int n, input int scans,
                        input int d, input bit den, input int src);
      @(negedge clk);
      cfg_sample_ivl = CNT_W'(s); cfg_scan_ivl = CNT_W'(sc);
      cfg_num_ch = CH_W'(n); cfg_num_scans = SCAN_W'(scans);
      cfg_delay = DLY_W'(d); cfg_delay_en = den; cfg_src = 2'(src);
   endtask

   task automatic pulse_trig();
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000 && acq_busy; i++) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic time_first(output int lat);
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      lat = 1;
      while (!conv_strobe && lat < 1000) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: run did not complete");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      int base, lat;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R6", "reset acq_busy", int'(acq_busy), 0);
      check("R2", "reset conv_strobe", int'(conv_strobe), 0);
      check("R9", "reset cfg_err", int'(cfg_err), 0);

      // R3: 4 channels x 3 scans on the timebase, post-trigger
      setup(2, 10, 4, 3, 0, 1'b0, 0);
      base = n_strobes;
      pulse_trig();
      wait_idle();
      check("R3", "strobes for 4x3", n_strobes - base, 12);

      // R7: post-trigger latency
      setup(1, 3, 3, 1, 0, 1'b0, 0);
      time_first(lat);
      check("R7", "post-trigger first strobe latency", lat, 2);
      wait_idle();

      // R7: delayed start by 5 ticks
      setup(3, 7, 2, 2, 5, 1'b1, 0);
      base = n_strobes;
      time_first(lat);
      check("R7", "delay-trigger first strobe latency", lat, 7);
      wait_idle();
      check("R3", "strobes for 2x2 delayed", n_strobes - base, 4);

      // R8: external pulse source, timer A toggling but not selected
      setup(1, 3, 3, 2, 0, 1'b0, 1);
      ext_run = 1'b1; tmr_a_run = 1'b1;
      base = n_strobes;
      pulse_trig();
      wait_idle();
      ext_run = 1'b0; tmr_a_run = 1'b0;
      check("R8", "strobes from ext source", n_strobes - base, 6);

      // R8: timer B held high gives a single tick
      setup(1, 2, 2, 1, 0, 1'b0, 3);
      base = n_strobes;
      pulse_trig();
      @(negedge clk); tmr_b_pulse = 1'b1;
      repeat (10) @(negedge clk);
      check("R8", "one tick from held level", n_strobes - base, 1);
      tmr_b_pulse = 1'b0;
      @(negedge clk); tmr_b_pulse = 1'b1;
      @(negedge clk); tmr_b_pulse = 1'b0;
      wait_idle();
      check("R8", "second tick after new edge", n_strobes - base, 2);

      // R9: scan interval too short is refused
      setup(3, 8, 3, 2, 0, 1'b0, 0);
      base = n_strobes;
      pulse_trig();
      check("R9", "cfg_err after bad setting", int'(cfg_err), 1);
      check("R9", "no start after bad setting", int'(acq_busy), 0);
      repeat (20) @(negedge clk);
      check("R9", "no strobes after bad setting", n_strobes - base, 0);
      setup(0, 8, 3, 2, 0, 1'b0, 0);
      pulse_trig();
      check("R9", "zero sample interval refused", int'(acq_busy), 0);

      // R1, R10: retrigger and config change mid-run are ignored
      setup(2, 8, 3, 2, 0, 1'b0, 0);
      base = n_strobes;
      pulse_trig();
      check("R9", "valid trigger clears cfg_err", int'(cfg_err), 0);
      repeat (3) @(negedge clk);
      cfg_num_ch = CH_W'(5); cfg_num_scans = SCAN_W'(4); cfg_sample_ivl = CNT_W'(0);
      trig = 1'b1;
      @(negedge clk); trig = 1'b0;
      check("R10", "busy kept through retrigger", int'(acq_busy), 1);
      check("R10", "cfg_err unaffected by retrigger", int'(cfg_err), 0);
      wait_idle();
      check("R1", "strobes use captured setting", n_strobes - base, 6);

      // R5: one channel per scan, back-to-back scans
      setup(1, 1, 1, 5, 0, 1'b0, 0);
      base = n_strobes;
      pulse_trig();
      wait_idle();
      check("R5", "single-channel scans", n_strobes - base, 5);
      check("R6", "idle at end", int'(acq_busy), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule